// File: doc/BRIEF.md
# Split-Edge Three-Port Register File

This block is the general-purpose register store of a small load/store processor datapath. It keeps a bank of word-wide registers, reads two of them and writes one of them in every clock cycle. Each port is addressed by a register index taken straight from the instruction fields. The two read results feed the ALU operand paths, and the write port takes the result bus coming back from the ALU or from memory.

The two halves of the clock cycle do different work. A write lands on the falling edge, and only when the write-enable control is high. The read outputs are captured on the rising edge. A value written in the second half of a cycle can therefore be read on the next rising edge, with no bypass path. Entry zero is hard-wired to zero. An active-low asynchronous reset clears the whole bank and both read outputs.

Top module: `regfile_split_edge`

## Requirements
- R1: While `rst_n` is low, every register and both read outputs are zero, and they become zero without waiting for a clock edge. After release, reading any index returns zero until that index is written.
- R2: Each read output changes only on a rising clock edge. A change of a read address between rising edges leaves the output as it was until the next rising edge.
- R3: On a falling edge with `wr_en` high, the register at index `wr_idx` (unsigned binary, 1 to 31) takes `wr_data`, and no other register changes. This holds for the lowest index 1 and the highest index 31.
- R4: On a falling edge with `wr_en` low, no register changes, whatever the values of `wr_idx` and `wr_data`.
- R5: Index 0 always reads as zero on both ports, and a write to index 0 has no effect.
- R6: When a read index equals the write index of a write with `wr_en` high, the rising edge after that falling-edge write returns the new value on that read port.
- R7: The two read ports are independent. Each one returns the register at its own index, and both return the same value when they address the same register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Reads are captured on the rising edge and writes on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 5 | Register index for read port A |
| rd_b_idx | input | 5 | Register index for read port B |
| rd_a_data | output | 32 | Registered read data for port A |
| rd_b_data | output | 32 | Registered read data for port B |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Register index for the write port |
| wr_data | input | 32 | Write data, offered to every entry |

## Verification
The bench builds the block with its default parameters: 32-bit data and a 5-bit index. At these values the whole bank of 32 entries can be addressed, so the tests reach the boundary entries 1 and 31 as well as the fixed zero entry. A sweep after a single write reads every index on both ports. This shows that the write decode updates exactly one entry. Inputs are driven just after the rising edge, so each write lands on the following falling edge. This setup exercises both same-cycle write-then-read and the hold of a read output between rising edges.

// File: rtl/regfile_split_edge.sv
module regfile_split_edge #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_a_idx,
  input  logic [ADDR_W-1:0] rd_b_idx,
  output logic [DATA_W-1:0] rd_a_data,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] bank [DEPTH];
  logic [DEPTH-1:0]  row_we;

  for (genvar i = 0; i < DEPTH; i++) begin : g_dec
    if (i == 0) begin : g_zero
      assign row_we[i] = 1'b0;
    end else begin : g_row
      assign row_we[i] = wr_en && (wr_idx == ADDR_W'(i));
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) bank[i] <= '0;
    end else begin
      for (int i = 1; i < DEPTH; i++)
        if (row_we[i]) bank[i] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_a_data <= '0;
      rd_b_data <= '0;
    end else begin
      rd_a_data <= (rd_a_idx == '0) ? '0 : bank[rd_a_idx];
      rd_b_data <= (rd_b_idx == '0) ? '0 : bank[rd_b_idx];
    end
  end

  // R1
  rst_out_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rd_a_data == '0 && rd_b_data == '0));

  // R5
  zero_idx_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == '0) |=> (rd_a_data == '0));

  // R5
  zero_idx_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_idx == '0) |=> (rd_b_data == '0));

  // R6
  wr_through_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != '0 && wr_idx == rd_a_idx) |=> (rd_a_data == $past(wr_data)));

  // R6
  wr_through_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != '0 && wr_idx == rd_b_idx) |=> (rd_b_data == $past(wr_data)));

  // R7
  ports_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == rd_b_idx) |=> (rd_a_data == rd_b_data));

endmodule

// File: tb/regfile_split_edge_bench.sv
`timescale 1ns/1ps
module regfile_split_edge_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  regfile_split_edge u_regfile_split_edge (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
    .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  // we | wr_idx | wr_data | rd_a | rd_b | exp_a | exp_b
  localparam int NV = 9;
  localparam logic [111:0] VEC [NV] = '{
    {1'b1, 5'd3,  32'hA5A5_0003, 5'd3,  5'd0,  32'hA5A5_0003, 32'h0},
    {1'b1, 5'd7,  32'h1234_5678, 5'd3,  5'd7,  32'hA5A5_0003, 32'h1234_5678},
    {1'b0, 5'd3,  32'hFFFF_FFFF, 5'd3,  5'd7,  32'hA5A5_0003, 32'h1234_5678},
    {1'b1, 5'd0,  32'hDEAD_BEEF, 5'd0,  5'd0,  32'h0,         32'h0},
    {1'b1, 5'd31, 32'h8000_0001, 5'd31, 5'd3,  32'h8000_0001, 32'hA5A5_0003},
    {1'b1, 5'd3,  32'h0000_00FF, 5'd3,  5'd31, 32'h0000_00FF, 32'h8000_0001},
    {1'b0, 5'd31, 32'h0,         5'd31, 5'd0,  32'h8000_0001, 32'h0},
    {1'b1, 5'd1,  32'hFFFF_FFFF, 5'd7,  5'd1,  32'h1234_5678, 32'hFFFF_FFFF},
    {1'b1, 5'd2,  32'h0,         5'd1,  5'd2,  32'hFFFF_FFFF, 32'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [4:0] wa, input logic [31:0] wd,
                      input logic [4:0] ra, input logic [4:0] rb);
    wr_en = we; wr_idx = wa; wr_data = wd; rd_a_idx = ra; rd_b_idx = rb;
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    chk("R1 reset port a", rd_a_data, 32'h0);
    chk("R1 reset port b", rd_b_data, 32'h0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    step(1'b0, 5'd0, 32'h0, 5'd5, 5'd31);
    chk("R1 post-reset a", rd_a_data, 32'h0);
    chk("R1 post-reset b", rd_b_data, 32'h0);

    for (int v = 0; v < NV; v++) begin
      step(VEC[v][111], VEC[v][110:106], VEC[v][105:74], VEC[v][73:69], VEC[v][68:64]);
      chk($sformatf("R3/R4/R5/R6/R7 vec %0d port a", v), rd_a_data, VEC[v][63:32]);
      chk($sformatf("R3/R4/R5/R6/R7 vec %0d port b", v), rd_b_data, VEC[v][31:0]);
    end

    // R2: address changes between rising edges leave outputs unchanged
    rd_a_idx = 5'd1; rd_b_idx = 5'd7;
    #2;
    chk("R2 hold a", rd_a_data, 32'hFFFF_FFFF);
    chk("R2 hold b", rd_b_data, 32'h0);
    @(posedge clk); #1;
    chk("R2 update b", rd_b_data, 32'h1234_5678);

    // R1: asynchronous reset mid-run
    rst_n = 1'b0;
    #0.5;
    chk("R1 async a", rd_a_data, 32'h0);
    chk("R1 async b", rd_b_data, 32'h0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    step(1'b0, 5'd0, 32'h0, 5'd3, 5'd31);
    chk("R1 bank cleared a", rd_a_data, 32'h0);
    chk("R1 bank cleared b", rd_b_data, 32'h0);

    // R3: a single write touches only its own entry
    step(1'b1, 5'd16, 32'hC0DE_0016, 5'd0, 5'd0);
    for (int i = 0; i < 32; i++) begin
      step(1'b0, 5'd16, 32'hFFFF_FFFF, 5'(i), 5'(31 - i));
      chk($sformatf("R3 sweep a idx %0d", i), rd_a_data, (i == 16) ? 32'hC0DE_0016 : 32'h0);
      chk($sformatf("R3 sweep b idx %0d", 31 - i), rd_b_data, (31 - i == 16) ? 32'hC0DE_0016 : 32'h0);
    end

    // R5: write to index 0 then read it
    step(1'b1, 5'd0, 32'h5555_AAAA, 5'd0, 5'd16);
    step(1'b0, 5'd0, 32'h0, 5'd0, 5'd0);
    chk("R5 zero a", rd_a_data, 32'h0);
    chk("R5 zero b", rd_b_data, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule